// File: doc/BRIEF.md
# Stereo Soft Mute and Silence Detector

This block sits in a stereo sample pipeline and fades both channels down to silence, and back up again, in response to a single mute request. Each accepted frame carries one left and one right two's-complement sample. The block multiplies both samples by a shared linear gain and rounds the result. The gain moves by one step per accepted frame, toward zero while the request is high and toward unity while it is low. A full fade in either direction takes a fixed number of frames. A request that flips partway through a fade reverses the ramp from whatever level it has reached.

A separate watcher counts consecutive frames in which both input channels are exactly zero. It raises a flag once the run reaches a set length. One frame with any nonzero input sample drops the flag at once and restarts the count. The watcher looks at the incoming samples, not the attenuated ones, so a muted but live stream does not read as silence.

Top module: `soft_mute_zero`

## Requirements
- R1: While rstN is low and after it is released, outValid, outLeft, outRight and zeroFlag are 0. The gain starts at unity, so the first frame after reset passes through unchanged.
- R2: A frame presented with inValid high at a clock edge produces outValid high for exactly the following cycle, with the scaled samples on outLeft/outRight. Cycles without inValid give outValid low.
- R3: Each output sample equals floor((sample * g + 512) / 1024), where g is the gain in force for that frame (0..1024, unity = 1024). Unity therefore passes samples exactly and g = 0 gives exactly 0.
- R4: For each valid frame with muteReq high, g drops by 1 after the frame is scaled, stopping at 0. From unity it takes 1024 frames to reach silence.
- R5: For each valid frame with muteReq low, g rises by 1 after the frame is scaled, stopping at 1024.
- R6: Dropping muteReq partway through a fade makes the next frames climb from the level already reached, one step per frame. Raising it again descends the same way.
- R7: Cycles with inValid low change neither the gain nor the silence count, whatever muteReq and the sample inputs do.
- R8: zeroFlag goes high in the cycle after the 8192nd consecutive valid frame whose left and right samples are both 0, and not earlier.
- R9: A valid frame with either sample nonzero drives zeroFlag low in the following cycle and restarts the count from zero.
- R10: The silence count saturates: zeroFlag stays high for as long as all-zero frames continue, with no wrap.
- R11: zeroFlag is low whenever rstN is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Frame strobe for inLeft/inRight |
| inLeft | input | DATA_W | Left sample, two's complement |
| inRight | input | DATA_W | Right sample, two's complement |
| muteReq | input | 1 | Mute request, active high |
| outValid | output | 1 | Output frame strobe |
| outLeft | output | DATA_W | Attenuated left sample |
| outRight | output | DATA_W | Attenuated right sample |
| zeroFlag | output | 1 | High after a long run of all-zero input frames |

## Verification
Several properties are checked on every cycle:
- the one-cycle output strobe;
- the magnitude bound that attenuation never amplifies;
- zero input giving zero output;
- the flag being low in reset;
- the flag dropping after a nonzero frame;
- the flag rising only after an all-zero frame.

The exact rounding, the frame-by-frame shape of each fade, the turnaround at an intermediate level and the exact 8192-frame threshold depend on history across thousands of frames. Only the bench's scenarios show these, by comparing against a model of the gain.

// File: rtl/smz_pkg.sv
package smz_pkg;

  // Per-frame commands from the ramp control to the gain datapath.
  typedef struct packed {
    logic capture;   // scale this frame and present it next cycle
    logic stepDown;  // move gain one step toward silence
    logic stepUp;    // move gain one step toward unity
  } smz_strobe_t;

endpackage

// File: rtl/smz_ramp_ctrl.sv
module smz_ramp_ctrl
  import smz_pkg::*;
(
  input  logic        inValid,
  input  logic        muteReq,
  input  logic        atFloor,
  input  logic        atCeil,
  output smz_strobe_t strobe
);

  // The direction follows the request on every frame, so a withdrawn
  // request turns the ramp around at whatever level it has reached.
  always_comb begin
    strobe.capture  = inValid;
    strobe.stepDown = inValid && muteReq && !atFloor;
    strobe.stepUp   = inValid && !muteReq && !atCeil;
  end

endmodule

// File: rtl/smz_gain_path.sv
module smz_gain_path
  import smz_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  smz_strobe_t              strobe,
  input  logic signed [DATA_W-1:0] inLeft,
  input  logic signed [DATA_W-1:0] inRight,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outLeft,
  output logic signed [DATA_W-1:0] outRight,
  output logic                     atFloor,
  output logic                     atCeil
);

  localparam int GW     = GAIN_W + 1;
  localparam int PROD_W = DATA_W + GAIN_W + 2;
  localparam logic [GW-1:0] UNITY = GW'(1) << GAIN_W;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (GAIN_W - 1);
  localparam int NCH = 2;

  logic [GW-1:0] gain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gain <= UNITY;
    else if (strobe.stepDown) gain <= gain - GW'(1);
    else if (strobe.stepUp)   gain <= gain + GW'(1);
  end

  assign atFloor = (gain == '0);
  assign atCeil  = (gain == UNITY);

  function automatic logic signed [DATA_W-1:0] scaleSample(
    input logic signed [DATA_W-1:0] sample,
    input logic        [GW-1:0]     g
  );
    logic signed [PROD_W-1:0] a;
    logic signed [PROD_W-1:0] b;
    logic signed [PROD_W-1:0] p;
    a = PROD_W'(sample);
    b = $signed(PROD_W'(g));
    p = a * b + HALF;
    return DATA_W'(p >>> GAIN_W);
  endfunction

  logic signed [DATA_W-1:0] chIn  [NCH];
  logic signed [DATA_W-1:0] chOut [NCH];

  assign chIn[0] = inLeft;
  assign chIn[1] = inRight;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               chOut[ch] <= '0;
      else if (strobe.capture) chOut[ch] <= scaleSample(chIn[ch], gain);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.capture;
  end

  assign outLeft  = chOut[0];
  assign outRight = chOut[1];

endmodule

// File: rtl/smz_silence_watch.sv
module smz_silence_watch #(
  parameter int DATA_W      = 24,
  parameter int ZERO_FRAMES = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic              zeroFlag
);

  localparam int CNT_W = $clog2(ZERO_FRAMES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ZERO_FRAMES);

  logic [CNT_W-1:0] runLen;
  logic             silentFrame;

  assign silentFrame = (inLeft == '0) && (inRight == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (inValid) begin
      if (!silentFrame)        runLen <= '0;
      else if (runLen != LIMIT) runLen <= runLen + CNT_W'(1);
    end
  end

  assign zeroFlag = (runLen == LIMIT);

endmodule

// File: rtl/soft_mute_zero.sv
module soft_mute_zero
  import smz_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int GAIN_W      = 10,
  parameter int ZERO_FRAMES = 8192
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inLeft,
  input  logic signed [DATA_W-1:0] inRight,
  input  logic                     muteReq,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outLeft,
  output logic signed [DATA_W-1:0] outRight,
  output logic                     zeroFlag
);

  smz_strobe_t strobe;
  logic        atFloor;
  logic        atCeil;

  smz_ramp_ctrl u_ctrl (
    .inValid (inValid),
    .muteReq (muteReq),
    .atFloor (atFloor),
    .atCeil  (atCeil),
    .strobe  (strobe)
  );

  smz_gain_path #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .outValid (outValid),
    .outLeft  (outLeft),
    .outRight (outRight),
    .atFloor  (atFloor),
    .atCeil   (atCeil)
  );

  smz_silence_watch #(.DATA_W(DATA_W), .ZERO_FRAMES(ZERO_FRAMES)) u_watch (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: rtl/smz_checker.sv
module smz_checker #(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inLeft,
  input logic signed [DATA_W-1:0] inRight,
  input logic                     muteReq,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outLeft,
  input logic signed [DATA_W-1:0] outRight,
  input logic                     zeroFlag
);

  function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
    logic signed [DATA_W:0] w;
    w = (DATA_W+1)'(v);
    return (w < 0) ? (DATA_W+1)'(-w) : (DATA_W+1)'(w);
  endfunction

  // R11: flag held low in reset
  a_r11_flag_low_in_reset: assert property (@(posedge clk)
    !rstN |-> !zeroFlag);

  // R2: valid frame yields output strobe next cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2: no frame, no output strobe
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: attenuation never increases magnitude
  a_r3_no_gain_left: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> mag(outLeft) <= mag($past(inLeft)));

  a_r3_no_gain_right: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> mag(outRight) <= mag($past(inRight)));

  // R3: zero in gives zero out
  a_r3_zero_maps_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLeft == '0 && inRight == '0) |=> (outLeft == '0 && outRight == '0));

  // R9: any nonzero frame clears the flag
  a_r9_flag_drops: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inLeft != '0 || inRight != '0)) |=> !zeroFlag);

  // R8: flag rises only after an all-zero valid frame
  a_r8_rise_after_silence: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zeroFlag) |-> $past(inValid && inLeft == '0 && inRight == '0));

  // R7: without a frame the flag cannot change
  a_r7_flag_stable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(zeroFlag));

  logic unusedMute;
  assign unusedMute = muteReq;

endmodule

bind soft_mute_zero smz_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inLeft   (inLeft),
  .inRight  (inRight),
  .muteReq  (muteReq),
  .outValid (outValid),
  .outLeft  (outLeft),
  .outRight (outRight),
  .zeroFlag (zeroFlag)
);

// File: tb/soft_mute_zero_bench.sv
module soft_mute_zero_bench;

  localparam int DW    = 24;
  localparam int UNITY = 1024;
  localparam int ZF    = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inLeft = '0;
  logic signed [DW-1:0] inRight = '0;
  logic muteReq = 1'b0;
  logic outValid;
  logic signed [DW-1:0] outLeft;
  logic signed [DW-1:0] outRight;
  logic zeroFlag;

  int compared = 0;
  int mismatched = 0;
  int g = UNITY;   // bench model of the gain
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  soft_mute_zero u_soft_mute_zero (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .muteReq(muteReq), .outValid(outValid), .outLeft(outLeft), .outRight(outRight),
    .zeroFlag(zeroFlag)
  );

  // {left, right, expLeft, expRight} at unity gain (R3)
  localparam logic [4*DW-1:0] VEC [6] = '{
    {24'h000000, 24'h000000, 24'h000000, 24'h000000},
    {24'h000001, 24'hFFFFFF, 24'h000001, 24'hFFFFFF},
    {24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000},
    {24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
    {24'hFFFFFB, 24'h000005, 24'hFFFFFB, 24'h000005},
    {24'h000400, 24'hFFFC00, 24'h000400, 24'hFFFC00}
  };

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint rnd(input longint s, input int gg);
    return (s * gg + 512) >>> 10;
  endfunction

  // Called at a negedge; drives a frame, returns at the next negedge.
  task automatic frame(input logic signed [DW-1:0] l, input logic signed [DW-1:0] r,
                       input logic m);
    inValid = 1'b1; inLeft = l; inRight = r; muteReq = m;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Frame checked against the gain model, then model steps (R4, R5)
  task automatic modelFrame(input string req, input logic signed [DW-1:0] l,
                            input logic signed [DW-1:0] r, input logic m);
    longint eL, eR;
    eL = rnd(l, g); eR = rnd(r, g);
    frame(l, r, m);
    check(req, outValid, 1);
    check(req, outLeft, eL);
    check(req, outRight, eR);
    if (m) begin if (g > 0) g--; end
    else   begin if (g < UNITY) g++; end
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", zeroFlag, 0);
    check("R1", outValid, 0);
    rstN = 1'b1; g = UNITY;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R11", zeroFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", outValid, 0);
    check("R1", outLeft, 0);
    check("R1", outRight, 0);
    check("R1", zeroFlag, 0);

    // R2/R3 unity vectors (also R1: first frame unchanged)
    for (int i = 0; i < 6; i++) begin
      frame(VEC[i][4*DW-1:3*DW], VEC[i][3*DW-1:2*DW], 1'b0);
      check("R2", outValid, 1);
      check("R3", outLeft,  $signed(VEC[i][2*DW-1:DW]));
      check("R3", outRight, $signed(VEC[i][DW-1:0]));
    end
    @(negedge clk);
    check("R2", outValid, 0);

    // R4: full fade down, output tracks gain 1024..1 then 0
    for (int i = 0; i < 1030; i++) modelFrame("R4", 24'sd1024, -24'sd1024, 1'b1);
    check("R4", g, 0);
    frame(24'h7FFFFF, 24'h800000, 1'b1);
    check("R3", outLeft, 0);
    check("R3", outRight, 0);

    // R5: fade back up to unity, then saturate
    for (int i = 0; i < 1030; i++) modelFrame("R5", 24'sd1024, -24'sd1024, 1'b0);
    frame(24'h123456, 24'h000007, 1'b0);
    check("R5", outLeft, 24'sh123456);
    check("R5", outRight, 7);

    // Fade down to 512, then rounding at half gain
    for (int i = 0; i < 512; i++) modelFrame("R4", 24'sd1024, 24'sd0, 1'b1);
    frame(24'sd3, -24'sd3, 1'b1);
    check("R3", outLeft, 2);
    check("R3", outRight, -1);
    g = 511;
    modelFrame("R3", 24'sd1, -24'sd1, 1'b1);   // 511 -> (511+512)>>10 = 0

    // R7: idle cycles with changing mute and data leave gain alone
    inLeft = 24'sd77; inRight = 24'sd77;
    for (int i = 0; i < 6; i++) begin
      muteReq = i[0];
      @(negedge clk);
      check("R7", outValid, 0);
    end
    frame(24'sd1024, 24'sd0, 1'b1);
    check("R7", outLeft, 510);
    g = 509;

    // R6: release mid-fade, climb from current level, then reverse again
    frame(24'sd1024, 24'sd0, 1'b0);
    check("R6", outLeft, 509);
    g = 510;
    frame(24'sd1024, 24'sd0, 1'b0);
    check("R6", outLeft, 510);
    g = 511;
    for (int i = 0; i < 100; i++) modelFrame("R6", 24'sd1024, -24'sd2048, 1'b0);
    for (int i = 0; i < 50; i++)  modelFrame("R6", 24'sd1024, -24'sd2048, 1'b1);
    check("R6", g, 561);

    // R8: exact threshold
    doReset();
    for (int i = 0; i < ZF - 1; i++) frame(24'sd0, 24'sd0, 1'b0);
    check("R8", zeroFlag, 0);
    frame(24'sd0, 24'sd0, 1'b0);
    check("R8", zeroFlag, 1);

    // R10: long silence beyond counter wrap point stays flagged
    for (int i = 0; i < 10000; i++) frame(24'sd0, 24'sd0, 1'b0);
    check("R10", zeroFlag, 1);

    // R9: nonzero right only drops flag, count restarts
    frame(24'sd0, 24'sd1, 1'b0);
    check("R9", zeroFlag, 0);
    for (int i = 0; i < 4000; i++) frame(24'sd0, 24'sd0, 1'b0);
    // R7: invalid nonzero data does not restart the count
    inLeft = 24'sd5; inRight = -24'sd5;
    repeat (5) @(negedge clk);
    check("R7", zeroFlag, 0);
    for (int i = 0; i < ZF - 4001; i++) frame(24'sd0, 24'sd0, 1'b0);
    check("R8", zeroFlag, 0);
    frame(24'sd0, 24'sd0, 1'b0);
    check("R8", zeroFlag, 1);
    frame(-24'sd1, 24'sd0, 1'b0);
    check("R9", zeroFlag, 0);

    // R11: reset while flagged
    for (int i = 0; i < ZF; i++) frame(24'sd0, 24'sd0, 1'b0);
    check("R10", zeroFlag, 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R11", zeroFlag, 0);
    check("R1", outLeft, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", zeroFlag, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule